// File: doc/BRIEF.md
# Boundary-Scan I/O Port Chain

This block places a serial test chain around a group of bidirectional I/O pins. Each pin has three scan cells. The first observes the real pin level. The second holds the output data. The third holds the output enable. A test access port controller outside this block drives the capture, shift and update strobes and the external-test select. It also supplies serial data from TDI, and the chain returns serial data toward TDO.

In normal operation the core's output enable and output data go straight to the pad. When the external-test select is high, an update stage of latches drives the pad instead. Those latches load on the falling clock edge of an update strobe. Because they keep their value, the pins take the scanned values the moment external test is selected, with no further scan. After reset the latches make every pin an input with data 0.

Top module: `bscan_io_chain`

## Requirements
- R1: While trst_n is low and after its release, every update latch holds output enable 0 and output data 0, and the shift chain is all zero, so tdo reads 0.
- R2: On a rising tck with capture_dr high, the chain loads each pin's state. Pin i's observe cell at chain position 3i takes pad_in[i]. Its data cell at position 3i+1 takes the driven pad_out[i]. Its direction cell at position 3i+2 takes the driven pad_oe[i]. Capture takes priority over shift.
- R3: On a rising tck with shift_dr high, the chain moves one place toward position 0. tdi enters position 3*NPIN-1, and tdo always shows position 0. A word shifted in least significant bit first therefore comes out in the same bit order.
- R4: On a falling tck with update_dr high, pin i's latches load output enable from position 3i+2 and output data from position 3i+1. They change on no other edge.
- R5: While extest is high, pad_oe and pad_out equal the update latches in the same cycle extest rises, with no further scan needed.
- R6: While extest is low, pad_oe equals core_oe and pad_out equals core_out, whatever the update latches hold.
- R7: On a rising tck with neither capture_dr nor shift_dr high, the chain keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into the chain |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| extest | input | 1 | External test instruction is active |
| tdo | output | 1 | Serial data out of the chain |
| core_oe | input | NPIN | Output enables from the core |
| core_out | input | NPIN | Output data from the core |
| pad_in | input | NPIN | Real level seen at each pad |
| pad_oe | output | NPIN | Output enable to each pad |
| pad_out | output | NPIN | Output data to each pad |

## Verification
The assertions check, on every cycle, four rules tied to single edges. They cover entry of tdi at the chain head, capture of pin 0's level to tdo, the chain holding still with no strobe, and the update latches loading only at an update falling edge. Only the bench scenarios can show that whole words come out in the right order. The same holds for the field positions in a captured word, and for the hand-over between core and scanned values when extest toggles. The bench also shows that an update in normal mode leaves the pins untouched.

// File: rtl/bscan_io_chain.sv
module bscan_io_chain #(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            extest,
  output logic            tdo,
  input  logic [NPIN-1:0] core_oe,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out
);
  localparam int LEN = 3 * NPIN;

  logic [LEN-1:0]  chain;
  logic [LEN-1:0]  snap;
  logic [NPIN-1:0] hold_oe;
  logic [NPIN-1:0] hold_out;

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_cell
    assign snap[3*gi]   = pad_in[gi];
    assign snap[3*gi+1] = pad_out[gi];
    assign snap[3*gi+2] = pad_oe[gi];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         chain <= '0;
    else if (capture_dr) chain <= snap;
    else if (shift_dr)   chain <= {tdi, chain[LEN-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      hold_oe  <= '0;
      hold_out <= '0;
    end else if (update_dr) begin
      for (int i = 0; i < NPIN; i++) begin
        hold_oe[i]  <= chain[3*i+2];
        hold_out[i] <= chain[3*i+1];
      end
    end
  end

  assign tdo     = chain[0];
  assign pad_oe  = extest ? hold_oe  : core_oe;
  assign pad_out = extest ? hold_out : core_out;

  a_r2_capture_pin0: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr |=> tdo == $past(pad_in[0]));

  a_r3_tdi_enters_head: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr) |=> chain[LEN-1] == $past(tdi));

  a_r7_idle_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (!shift_dr && !capture_dr) |=> $stable(chain));

  a_r4_latch_only_on_update: assert property (@(negedge tck) disable iff (!trst_n)
    !update_dr |=> ($stable(hold_oe) && $stable(hold_out)));

  a_r4_latch_pin0: assert property (@(negedge tck) disable iff (!trst_n)
    update_dr |=> (hold_oe[0] == $past(chain[2]) && hold_out[0] == $past(chain[1])));
endmodule

// File: tb/bscan_io_chain_tb.sv
module bscan_io_chain_tb;
  localparam int NPIN = 4;
  localparam int LEN  = 3 * NPIN;

  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, extest = 1'b0;
  logic tdo;
  logic [NPIN-1:0] core_oe = '0, core_out = '0, pad_in = '0, pad_oe, pad_out;

  bscan_io_chain #(.NPIN(NPIN)) u_dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .extest(extest), .tdo(tdo),
    .core_oe(core_oe), .core_out(core_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out));

  always #10 tck = ~tck;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_q[$];
  logic [NPIN-1:0] m_oe = '0, m_out = '0;

  task automatic step();
    @(posedge tck); #2;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NPIN-1:0] oe_of(input logic [LEN-1:0] w);
    for (int i = 0; i < NPIN; i++) oe_of[i] = w[3*i+2];
  endfunction

  function automatic logic [NPIN-1:0] out_of(input logic [LEN-1:0] w);
    for (int i = 0; i < NPIN; i++) out_of[i] = w[3*i+1];
  endfunction

  function automatic logic [LEN-1:0] cap_model();
    logic [NPIN-1:0] eo, ed;
    logic [LEN-1:0] w;
    eo = extest ? m_oe : core_oe;
    ed = extest ? m_out : core_out;
    for (int i = 0; i < NPIN; i++) begin
      w[3*i] = pad_in[i]; w[3*i+1] = ed[i]; w[3*i+2] = eo[i];
    end
    return w;
  endfunction

  // monitor: R3 bit order on tdo, one expected bit per shift cycle
  always @(negedge tck) begin
    if (shift_dr) begin
      if (exp_q.size() == 0) check(1'b0, "R3 (no expected bit)", {31'd0, tdo}, 32'd0);
      else begin
        logic e;
        e = exp_q.pop_front();
        check(tdo === e, "R3/R2 tdo bit", {31'd0, tdo}, {31'd0, e});
      end
    end
  end

  task automatic scan(input logic [LEN-1:0] din, input bit cap, input logic [LEN-1:0] exp_in, input bit upd);
    logic [LEN-1:0] expw;
    expw = exp_in;
    if (cap) begin
      expw = cap_model();
      capture_dr = 1'b1; step(); capture_dr = 1'b0;
    end
    for (int k = 0; k < LEN; k++) exp_q.push_back(expw[k]);
    shift_dr = 1'b1;
    for (int k = 0; k < LEN; k++) begin
      tdi = din[k]; step();
    end
    shift_dr = 1'b0; tdi = 1'b0;
    if (upd) begin
      update_dr = 1'b1; step(); update_dr = 1'b0;
      m_oe = oe_of(din); m_out = out_of(din);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] w1, w2, w3;
    #25; trst_n = 1'b1; step();
    // R1 reset state
    check(tdo === 1'b0, "R1 tdo after reset", {31'd0, tdo}, 32'd0);
    extest = 1'b1; #1;
    check(pad_oe === '0, "R1 latch oe reset", pad_oe, 0);
    check(pad_out === '0, "R1 latch out reset", pad_out, 0);
    extest = 1'b0;
    // R6 pass-through, several patterns
    for (int p = 0; p < 4; p++) begin
      core_oe = 4'(p * 5 + 3); core_out = 4'(p * 9 + 6); #1;
      check(pad_oe === core_oe, "R6 pad_oe follows core", pad_oe, core_oe);
      check(pad_out === core_out, "R6 pad_out follows core", pad_out, core_out);
    end
    // R2 capture in normal mode, shift in w1, update
    core_oe = 4'b1010; core_out = 4'b0110; pad_in = 4'b1100;
    w1 = 12'hA5C;
    scan(w1, 1'b1, '0, 1'b1);
    #1;
    check(pad_oe === core_oe, "R6 latches ignored oe", pad_oe, core_oe);
    check(pad_out === core_out, "R6 latches ignored out", pad_out, core_out);
    // R5 extest takes over immediately
    extest = 1'b1; #1;
    check(pad_oe === oe_of(w1), "R5 oe on extest", pad_oe, oe_of(w1));
    check(pad_out === out_of(w1), "R5 out on extest", pad_out, out_of(w1));
    // R7 idle cycles, then R3 chain still holds w1
    step(); step(); step();
    w2 = 12'h3C9;
    scan(w2, 1'b0, w1, 1'b0);
    // R4 no update -> pads unchanged
    check(pad_oe === oe_of(w1), "R4 no update oe", pad_oe, oe_of(w1));
    check(pad_out === out_of(w1), "R4 no update out", pad_out, out_of(w1));
    // R4 update loads on the falling edge only
    update_dr = 1'b1; #3;
    check(pad_oe === oe_of(w1), "R4 before falling edge", pad_oe, oe_of(w1));
    @(negedge tck); #2;
    check(pad_oe === oe_of(w2), "R4 oe after falling edge", pad_oe, oe_of(w2));
    check(pad_out === out_of(w2), "R4 out after falling edge", pad_out, out_of(w2));
    step(); update_dr = 1'b0;
    m_oe = oe_of(w2); m_out = out_of(w2);
    // R2 capture under extest sees latched drive and pad level
    pad_in = 4'b0011;
    w3 = 12'hF0F;
    scan(w3, 1'b1, '0, 1'b1);
    #1;
    check(pad_oe === oe_of(w3), "R4 oe w3", pad_oe, oe_of(w3));
    // R6 back to core
    extest = 1'b0; #1;
    check(pad_out === core_out, "R6 back to core", pad_out, core_out);
    step(); step();
    check(exp_q.size() == 0, "R3 all bits seen", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule